// File: doc/BRIEF.md
# Nonbinary Variable Node Update Unit

This block carries out the variable-node half of a Min-Max decoding iteration over GF(q) for a single variable node. Lower values mean more likely. It takes the node's channel reliability vector (the prior) and one incoming message vector from each connected check node. For every edge it returns an outgoing message that leaves out that edge's own contribution and is shifted so that its smallest entry is zero. It also returns the a posteriori reliability vector and the symbol that is currently most likely.

A run begins with a one-cycle `start` pulse and is followed by a serial stream of reliability values, one per cycle. An initialisation run carries only the prior. An iteration run carries the prior followed by every incoming vector. Once the last value has been taken, the block computes all results in a single cycle, registers them, and raises `done` for one cycle.

The block counts iteration runs since the last initialisation run. It combines that count with a syndrome-satisfied flag, sampled at `start`, to report whether decoding should stop.

Top module: `nbvn_update`

## Requirements
- R1: After reset, `done`, `stop`, `dec_sym`, `post_out` and `msg_out` are all zero.
- R2: Load protocol:
  - A `start` pulse samples `init_mode` and `syndrome_ok`.
  - Values with `load_valid` high are then accepted one per cycle. First come Q prior values for symbols 0..Q-1.
  - For an iteration run (`init_mode`=0), DV*Q incoming values follow, edge-major (edge 0 symbols 0..Q-1, then edge 1, ...).
  - `done` goes high one clock after the edge that accepts the final value and stays high for exactly one cycle.
- R3: In an initialisation run (prior with minimum zero), every edge's outgoing vector and the posterior equal the prior.
- R4: In an iteration run, the outgoing vector on edge e, before normalisation, is prior(a) plus the incoming values of all edges except e.
- R5: Each outgoing vector has its own minimum over the Q symbols subtracted, so every outgoing vector contains at least one zero.
- R6: The posterior is prior(a) plus the incoming values of all edges, saturated and not normalised.
- R7: `dec_sym` is the symbol with the smallest posterior. On a tie, the lowest symbol index is chosen.
- R8: All sums saturate at 2^W-1 before normalisation and never wrap.
- R9: `stop`, which is valid with `done`, is 1 in two cases:
  - the `syndrome_ok` sampled at `start` was 1; or
  - the number of iteration runs since the last initialisation run has reached MAX_ITER (default 10).

  An initialisation run clears that count.
- R10: `load_valid` values outside a load are ignored, and the outputs keep their values. A new `start` during a load abandons the partial load and restarts from the first prior value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a new load |
| init_mode | input | 1 | Sampled at start: 1 = initialisation run (prior only) |
| syndrome_ok | input | 1 | Sampled at start: all checks satisfied |
| load_valid | input | 1 | Qualifies load_data |
| load_data | input | W | Serial reliability value |
| done | output | 1 | One-cycle pulse qualifying the outputs |
| stop | output | 1 | Decoding should terminate |
| dec_sym | output | $clog2(Q) | Decided symbol |
| post_out | output | Q*W | Posterior, symbol a at bits a*W +: W |
| msg_out | output | DV*Q*W | Outgoing messages, edge e symbol a at bits (e*Q+a)*W +: W |

## Verification
The hardest condition to reach is the iteration limit. Because of the count, `stop` may rise only on the tenth consecutive iteration run after an initialisation run, and never earlier. The stimulus reaches it by issuing one initialisation run and then ten back-to-back iteration runs with the syndrome flag low, checking `stop` after each. Saturation and posterior ties are reached with chosen vectors: large incoming values, and two symbols given equal minimum sums.

// File: rtl/nbvn_update.sv
module nbvn_update #(
  parameter int Q        = 8,
  parameter int DV       = 3,
  parameter int W        = 8,
  parameter int MAX_ITER = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  init_mode,
  input  logic                  syndrome_ok,
  input  logic                  load_valid,
  input  logic [W-1:0]          load_data,
  output logic                  done,
  output logic                  stop,
  output logic [$clog2(Q)-1:0]  dec_sym,
  output logic [Q*W-1:0]        post_out,
  output logic [DV*Q*W-1:0]     msg_out
);

  localparam int SB    = $clog2(Q);
  localparam int SW    = W + $clog2(DV + 2);
  localparam int TOT   = Q + DV * Q;
  localparam int CW    = $clog2(TOT + 1);
  localparam int IW    = $clog2(MAX_ITER + 1);

  logic [W-1:0]  pri [Q];
  logic [W-1:0]  rin [DV*Q];
  logic          loading, calc, init_q, syn_q;
  logic [CW-1:0] cnt;
  logic [IW-1:0] iter;

  wire last_beat = init_q ? (cnt == CW'(Q - 1)) : (cnt == CW'(TOT - 1));
  wire accept    = loading && load_valid && !start;

  function automatic logic [W-1:0] sat(input logic [SW-1:0] v);
    return (|v[SW-1:W]) ? {W{1'b1}} : v[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loading <= 1'b0;
      calc    <= 1'b0;
      init_q  <= 1'b0;
      syn_q   <= 1'b0;
      cnt     <= '0;
      for (int i = 0; i < Q; i++) pri[i] <= '0;
      for (int i = 0; i < DV*Q; i++) rin[i] <= '0;
    end else begin
      calc <= accept && last_beat;
      if (start) begin
        loading <= 1'b1;
        cnt     <= '0;
        init_q  <= init_mode;
        syn_q   <= syndrome_ok;
        if (init_mode)
          for (int i = 0; i < DV*Q; i++) rin[i] <= '0;
      end else if (accept) begin
        for (int i = 0; i < Q; i++)
          if (cnt == CW'(i)) pri[i] <= load_data;
        for (int i = 0; i < DV*Q; i++)
          if (cnt == CW'(Q + i)) rin[i] <= load_data;
        cnt <= cnt + 1'b1;
        if (last_beat) loading <= 1'b0;
      end
    end
  end

  logic [SW-1:0] tot   [Q];
  logic [W-1:0]  post_c[Q];
  logic [W-1:0]  ext_c [DV][Q];
  logic [W-1:0]  mn    [DV];
  logic [SB-1:0] dec_c;

  always_comb begin
    for (int a = 0; a < Q; a++) begin
      tot[a] = SW'(pri[a]);
      for (int e = 0; e < DV; e++) tot[a] = tot[a] + SW'(rin[e*Q+a]);
      post_c[a] = sat(tot[a]);
    end
    for (int e = 0; e < DV; e++) begin
      mn[e] = {W{1'b1}};
      for (int a = 0; a < Q; a++) begin
        ext_c[e][a] = sat(tot[a] - SW'(rin[e*Q+a]));
        if (ext_c[e][a] < mn[e]) mn[e] = ext_c[e][a];
      end
    end
    dec_c = '0;
    for (int a = 0; a < Q; a++)
      if (post_c[a] < post_c[dec_c]) dec_c = SB'(a);
  end

  wire [IW-1:0] iter_n = init_q ? '0 : ((iter < IW'(MAX_ITER)) ? iter + 1'b1 : iter);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done     <= 1'b0;
      stop     <= 1'b0;
      dec_sym  <= '0;
      post_out <= '0;
      msg_out  <= '0;
      iter     <= '0;
    end else begin
      done <= calc;
      if (calc) begin
        iter    <= iter_n;
        stop    <= syn_q || (iter_n >= IW'(MAX_ITER));
        dec_sym <= dec_c;
        for (int a = 0; a < Q; a++) post_out[a*W +: W] <= post_c[a];
        for (int e = 0; e < DV; e++)
          for (int a = 0; a < Q; a++)
            msg_out[(e*Q+a)*W +: W] <= ext_c[e][a] - mn[e];
      end
    end
  end

  logic zero_ok, dec_ok;
  always_comb begin
    zero_ok = 1'b1;
    for (int e = 0; e < DV; e++) begin
      logic z;
      z = 1'b0;
      for (int a = 0; a < Q; a++)
        if (msg_out[(e*Q+a)*W +: W] == '0) z = 1'b1;
      zero_ok = zero_ok & z;
    end
    dec_ok = 1'b1;
    for (int a = 0; a < Q; a++) begin
      if (SB'(a) < dec_sym && !(post_out[a*W +: W] > post_out[dec_sym*W +: W])) dec_ok = 1'b0;
      if (post_out[a*W +: W] < post_out[dec_sym*W +: W]) dec_ok = 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_ZERO_IN_MSG: assert property (@(posedge clk) disable iff (!rst_n) done |-> zero_ok); // R5
  AST_DEC_ARGMIN: assert property (@(posedge clk) disable iff (!rst_n) done |-> dec_ok); // R7
  AST_ITER_CAP: assert property (@(posedge clk) disable iff (!rst_n) iter <= IW'(MAX_ITER)); // R9
  AST_LIMIT_STOP: assert property (@(posedge clk) disable iff (!rst_n) (done && iter == IW'(MAX_ITER)) |-> stop); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !$past(calc) |-> $stable(post_out)); // R10

endmodule

// File: tb/nbvn_update_tb_top.sv
module nbvn_update_tb_top;
  localparam int Q = 8, DV = 3, W = 8, MAXI = 10;
  localparam int CLK_PERIOD = 10;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0, start = 0, init_mode = 0, syndrome_ok = 0, load_valid = 0;
  logic [W-1:0] load_data = '0;
  logic done, stop;
  logic [$clog2(Q)-1:0] dec_sym;
  logic [Q*W-1:0] post_out;
  logic [DV*Q*W-1:0] msg_out;

  int checks = 0, errors = 0, runs = 0;
  int pri_m [Q];
  int rin_m [DV][Q];

  always #(CLK_PERIOD/2) clk = ~clk;

  nbvn_update #(.Q(Q), .DV(DV), .W(W), .MAX_ITER(MAXI)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .init_mode(init_mode),
    .syndrome_ok(syndrome_ok), .load_valid(load_valid), .load_data(load_data),
    .done(done), .stop(stop), .dec_sym(dec_sym), .post_out(post_out), .msg_out(msg_out));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic verify(input bit init, input bit syn, input string req);
    int post [Q];
    int best;
    bit exp_stop;
    for (int a = 0; a < Q; a++) begin
      int s = pri_m[a];
      if (!init) for (int e = 0; e < DV; e++) s += rin_m[e][a];
      post[a] = sat(s);
    end
    for (int e = 0; e < DV; e++) begin
      int ext [Q];
      int mn = MAXV;
      for (int a = 0; a < Q; a++) begin
        int s = pri_m[a];
        if (!init) for (int k = 0; k < DV; k++) if (k != e) s += rin_m[k][a];
        ext[a] = sat(s);
        if (ext[a] < mn) mn = ext[a];
      end
      for (int a = 0; a < Q; a++)
        chk({req, " R4 R5 R8"}, $sformatf("msg e%0d a%0d", e, a),
            int'(msg_out[(e*Q+a)*W +: W]), ext[a] - mn);
    end
    for (int a = 0; a < Q; a++)
      chk({req, " R6"}, $sformatf("post a%0d", a), int'(post_out[a*W +: W]), post[a]);
    best = 0;
    for (int a = 1; a < Q; a++) if (post[a] < post[best]) best = a;
    chk({req, " R7"}, "dec_sym", int'(dec_sym), best);
    if (init) runs = 0; else if (runs < MAXI) runs++;
    exp_stop = syn || (runs >= MAXI);
    chk({req, " R9"}, "stop", int'(stop), int'(exp_stop));
  endtask

  task automatic run(input bit init, input bit syn, input string req);
    int n;
    @(negedge clk); start = 1; init_mode = init; syndrome_ok = syn;
    @(negedge clk); start = 0;
    for (int a = 0; a < Q; a++) begin
      load_valid = 1; load_data = W'(pri_m[a]); @(negedge clk);
    end
    if (!init)
      for (int e = 0; e < DV; e++)
        for (int a = 0; a < Q; a++) begin
          load_valid = 1; load_data = W'(rin_m[e][a]); @(negedge clk);
        end
    load_valid = 0;
    n = 1;
    while (!done && n < 20) begin @(negedge clk); n++; end
    chk("R2", "done latency", n, 2);
    verify(init, syn, req);
    @(negedge clk);
    chk("R2", "done width", int'(done), 0);
  endtask

  task automatic set_pattern(input int seed, input int span);
    for (int a = 0; a < Q; a++) pri_m[a] = (a * 7 + seed * 3) % span + 1;
    pri_m[seed % Q] = 0;
    for (int e = 0; e < DV; e++)
      for (int a = 0; a < Q; a++) rin_m[e][a] = (a * 5 + e * 11 + seed * 13) % span;
  endtask

  task automatic t_reset;
    chk("R1", "done", int'(done), 0);
    chk("R1", "stop", int'(stop), 0);
    chk("R1", "dec_sym", int'(dec_sym), 0);
    chk("R1", "post_out", int'(post_out != '0), 0);
    chk("R1", "msg_out", int'(msg_out != '0), 0);
  endtask

  task automatic t_init;
    set_pattern(3, 30);
    run(1, 0, "R3");
    for (int e = 0; e < DV; e++)
      for (int a = 0; a < Q; a++)
        chk("R3", "msg equals prior", int'(msg_out[(e*Q+a)*W +: W]), pri_m[a]);
  endtask

  task automatic t_iterations;
    set_pattern(1, 40); run(0, 0, "R4");
    set_pattern(6, 25); run(0, 0, "R5");
    set_pattern(2, 60); run(0, 0, "R6");
  endtask

  task automatic t_tie;
    for (int a = 0; a < Q; a++) pri_m[a] = (a == 2 || a == 5) ? 0 : 4;
    run(1, 0, "R7 tie init");
    chk("R7", "tie init dec", int'(dec_sym), 2);
    for (int e = 0; e < DV; e++)
      for (int a = 0; a < Q; a++) rin_m[e][a] = (a == 2 || a == 5) ? 1 : 3;
    run(0, 0, "R7 tie iter");
    chk("R7", "tie iter dec", int'(dec_sym), 2);
  endtask

  task automatic t_saturate;
    for (int a = 0; a < Q; a++) pri_m[a] = (a == 4) ? 0 : 200;
    for (int e = 0; e < DV; e++)
      for (int a = 0; a < Q; a++) rin_m[e][a] = (a == 4) ? 10 + e : 150 + a;
    run(0, 0, "R8");
    chk("R8", "saturated post", int'(post_out[0 +: W]), MAXV);
  endtask

  task automatic t_limit;
    set_pattern(4, 20);
    run(1, 0, "R9 init");
    for (int k = 1; k <= MAXI; k++) begin
      set_pattern(k, 20);
      run(0, 0, "R9 limit");
    end
    chk("R9", "stop at limit", int'(stop), 1);
    run(1, 1, "R9 syn init");
    set_pattern(5, 30); run(0, 1, "R9 syn");
    run(0, 0, "R9 after syn");
    chk("R9", "no stop", int'(stop), 0);
  endtask

  task automatic t_ignore_restart;
    logic [Q*W-1:0] held;
    held = post_out;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); load_valid = 1; load_data = 8'd99;
      chk("R10", "stray done", int'(done), 0);
    end
    @(negedge clk); load_valid = 0;
    chk("R10", "post held", int'(post_out == held), 1);
    @(negedge clk); start = 1; init_mode = 0; syndrome_ok = 0;
    @(negedge clk); start = 0;
    for (int i = 0; i < 5; i++) begin
      load_valid = 1; load_data = 8'd77; @(negedge clk);
    end
    load_valid = 0;
    set_pattern(7, 35);
    run(0, 0, "R10 restart");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_init;
    t_iterations;
    t_tie;
    t_saturate;
    t_limit;
    t_ignore_restart;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule